// File: doc/BRIEF.md
# Descriptor-Chain Address Translation Walker

This block turns a 64-bit virtual address into a physical address by following a chain of 64-bit descriptors kept in memory. From the configured translation granule (4 KB, 16 KB or 64 KB) and the size-offset field it works out at which level the chain begins and how many address bits index the first table, aligns the root table pointer, and then fetches one 8-byte descriptor per level through a request/response read port. Every descriptor is classified as a pointer to a further table, a block leaf, a page leaf, or unusable, and access rights are tested on the way down.

A walk is launched with a one-cycle start pulse carrying the address and a write flag. The walker reports busy until it ends, then raises done for one cycle with either the leaf's output address, the aligned input address, the offset mask, the granted rights, the final level and the granule, or a fault class plus the address of the descriptor at fault. Result outputs hold until the next walk ends. Root-pointer choice and result caching belong to the surrounding logic.

Top module: `ptw_walker`

## Requirements
- R1: After reset, and whenever no walk is running, `xl_busy`, `xl_done` and `mem_req_valid` are low; `mem_req_valid` is only ever high while `xl_busy` is high.
- R2: With input size S = 64 − tsz and stride T = log2(granule) − 3, the first level is 4 − (S − 4)/T; the root table base is bits 47:0 of `cfg_base` with its low S − T·(4 − first level) bits cleared, and bits 63:48 of `cfg_base` have no effect.
- R3: At level L the walker reads the descriptor at base + 8·index, where index is the address shifted right by log2(granule) + (3 − L)·T and kept to T bits (to the remaining S − shift bits at the first level); one read is made per level visited and every read address is 8-byte aligned.
- R4: Descriptor bit 0 set means valid; bit 1 set at levels 0–2 marks a table, whose bits 47:log2(granule) (low bits cleared) form the next level's base.
- R5: A leaf (bit 1 set at level 3: page; bit 1 clear below level 3: block) gives `xl_fault`=0, `xl_pa` = descriptor bits 47:shift with lower bits zero, `xl_mask` = 2^shift − 1, `xl_va_out` = input address with the mask bits cleared, `xl_level` = L, `xl_gran` = log2(granule), and `xl_perm` = 2'b11 (bit 1 write, bit 0 read), or 2'b01 when descriptor bit 7 is set.
- R6: A descriptor with bit 0 clear, or with bit 1 clear at level 3, ends the walk with `xl_fault` = 1 (translation), `xl_fault_addr` = that descriptor's address and `xl_perm` = 0.
- R7: A read answered with `mem_rsp_err` ends the walk with `xl_fault` = 3 (external abort) and `xl_fault_addr` = the address of that read.
- R8: When `cfg_off` is set, `cfg_gran` is 3, or the first level computed by R2 falls outside 0–3, the walk ends with `xl_fault` = 1 without issuing any memory read.
- R9: A write request that reaches a leaf with bit 7 set ends with `xl_fault` = 2 (permission) and `xl_perm` = 0; a read of the same leaf succeeds; every faulted walk reports `xl_perm` = 0.
- R10: A write request that passes a table descriptor with bit 62 set ends with `xl_fault` = 2 at that descriptor unless `cfg_hpd` is set, in which case bit 62 has no effect; reads are never stopped by bit 62.
- R11: A pending read keeps `mem_req_valid` high and `mem_req_addr` unchanged until `mem_req_ready`; `xl_done` lasts exactly one cycle; a start pulse arriving while busy is ignored.
- R12: `cfg_gran` encodes the granule as 0 = 4 KB, 1 = 16 KB, 2 = 64 KB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_gran | input | 2 | Granule select |
| cfg_tsz | input | 6 | Size offset; input size is 64 minus this |
| cfg_base | input | 64 | Root table pointer |
| cfg_hpd | input | 1 | Ignore table-level write protection |
| cfg_off | input | 1 | Translation table disabled |
| xl_start | input | 1 | Start pulse, accepted when idle |
| xl_va | input | 64 | Address to translate |
| xl_write | input | 1 | Request is a write |
| xl_busy | output | 1 | Walk in progress |
| xl_done | output | 1 | One-cycle end-of-walk pulse |
| xl_fault | output | 2 | 0 none, 1 translation, 2 permission, 3 external abort |
| xl_fault_addr | output | 48 | Address of the faulting descriptor |
| xl_pa | output | 48 | Leaf output address |
| xl_va_out | output | 64 | Input address aligned to the leaf size |
| xl_mask | output | 64 | Leaf offset mask |
| xl_perm | output | 2 | Granted rights {write, read} |
| xl_level | output | 2 | Level where the walk ended |
| xl_gran | output | 5 | log2 of the granule |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 48 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Descriptor value |
| mem_rsp_err | input | 1 | Read failed |

## Verification
On every cycle the checker confirms that a stalled read request holds its address, that reads only appear while busy and are 8-byte aligned, that done is a single-cycle pulse at which busy is low, that a faulted walk grants no rights, and that a successful result never leaves offset bits in the aligned address. Whether the first level, root alignment, per-level indices, leaf sizes and fault classes are right for a given granule and size field can only be seen in the directed scenarios, which lay out descriptor chains in a memory model and compare the final result and the number of reads against values worked out from the requirements.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int PTW_VA_W   = 64;
    localparam int PTW_PA_W   = 48;
    localparam int PTW_DESC_W = 64;
    localparam int PTW_TSZ_W  = 6;
    localparam int PTW_GLOG_W = 5;
    localparam int PTW_LVL_W  = 2;
    localparam int PTW_SH_W   = 7;

    // descriptor bit positions
    localparam int D_VALID  = 0;
    localparam int D_KIND   = 1;
    localparam int D_LEAFRO = 7;
    localparam int D_TBLRO  = 62;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_REQ   = 2'd2,
        ST_WAIT  = 2'd3
    } ptw_state_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_XLAT  = 2'd1,
        FLT_PERM  = 2'd2,
        FLT_ABORT = 2'd3
    } ptw_fault_e;

    typedef enum logic [2:0] {
        K_INVALID  = 3'd0,
        K_RESERVED = 3'd1,
        K_TABLE    = 3'd2,
        K_PAGE     = 3'd3,
        K_BLOCK    = 3'd4
    } ptw_kind_e;

endpackage

// File: rtl/ptw_geom.sv
module ptw_geom
    import ptw_pkg::*;
#(
    parameter int TSZ_W  = PTW_TSZ_W,
    parameter int GLOG_W = PTW_GLOG_W,
    parameter int LVL_W  = PTW_LVL_W,
    parameter int SH_W   = PTW_SH_W
) (
    input  logic [1:0]        gran_sel,
    input  logic [TSZ_W-1:0]  tsz,
    input  logic [LVL_W-1:0]  lvl,
    output logic [GLOG_W-1:0] gran_log,
    output logic [LVL_W-1:0]  start_lvl,
    output logic              geom_ok,
    output logic [SH_W-1:0]   base_mbits,
    output logic [SH_W-1:0]   shift,
    output logic [SH_W-1:0]   idx_bits
);
    localparam int NFIT = 5;

    logic              gran_ok;
    logic [GLOG_W-1:0] stride;
    logic [SH_W-1:0]   isz;
    logic [NFIT-1:0]   fits;
    logic [2:0]        cnt;

    always_comb begin
        gran_ok = 1'b1;
        unique case (gran_sel)
            2'd0:    gran_log = GLOG_W'(12);
            2'd1:    gran_log = GLOG_W'(14);
            2'd2:    gran_log = GLOG_W'(16);
            default: begin
                gran_log = GLOG_W'(12);
                gran_ok  = 1'b0;
            end
        endcase
    end

    assign stride = gran_log - GLOG_W'(3);
    assign isz    = SH_W'(64) - SH_W'(tsz);

    // fits[k-1]: k strides fit in (isz - 4); their count gives the level span
    for (genvar k = 1; k <= NFIT; k++) begin : g_fit
        assign fits[k-1] = (isz >= SH_W'(4)) &&
                           ((8'(k) * 8'(stride)) <= (8'(isz) - 8'd4));
    end

    assign cnt        = 3'($countones(fits[3:0]));
    assign geom_ok    = gran_ok && fits[0] && !fits[NFIT-1];
    assign start_lvl  = LVL_W'(3'd4 - cnt);
    assign base_mbits = isz - SH_W'(cnt) * SH_W'(stride);
    assign shift      = SH_W'(gran_log) + SH_W'(2'd3 - lvl) * SH_W'(stride);
    assign idx_bits   = (lvl == start_lvl) ? (isz - shift) : SH_W'(stride);

endmodule

// File: rtl/ptw_desc.sv
module ptw_desc
    import ptw_pkg::*;
#(
    parameter int DESC_W = PTW_DESC_W,
    parameter int PA_W   = PTW_PA_W,
    parameter int GLOG_W = PTW_GLOG_W,
    parameter int LVL_W  = PTW_LVL_W,
    parameter int SH_W   = PTW_SH_W
) (
    input  logic [DESC_W-1:0] desc,
    input  logic [LVL_W-1:0]  lvl,
    input  logic [GLOG_W-1:0] gran_log,
    input  logic [SH_W-1:0]   shift,
    output ptw_kind_e         kind,
    output logic [PA_W-1:0]   next_base,
    output logic [PA_W-1:0]   leaf_pa,
    output logic              leaf_ro,
    output logic              tbl_ro
);
    localparam logic [LVL_W-1:0] LAST_LVL = {LVL_W{1'b1}};
    localparam logic [PA_W-1:0]  ONES     = {PA_W{1'b1}};

    logic [PA_W-1:0] field;
    logic            unused_desc;

    assign field       = desc[PA_W-1:0];
    assign unused_desc = ^desc;

    always_comb begin
        if (!desc[D_VALID]) begin
            kind = K_INVALID;
        end else if (lvl == LAST_LVL) begin
            kind = desc[D_KIND] ? K_PAGE : K_RESERVED;
        end else begin
            kind = desc[D_KIND] ? K_TABLE : K_BLOCK;
        end
    end

    assign next_base = field & (ONES << gran_log);
    assign leaf_pa   = field & (ONES << shift);
    assign leaf_ro   = desc[D_LEAFRO];
    assign tbl_ro    = desc[D_TBLRO];

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VA_W   = PTW_VA_W,
    parameter int PA_W   = PTW_PA_W,
    parameter int DESC_W = PTW_DESC_W,
    parameter int TSZ_W  = PTW_TSZ_W,
    parameter int GLOG_W = PTW_GLOG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_gran,
    input  logic [TSZ_W-1:0]  cfg_tsz,
    input  logic [VA_W-1:0]   cfg_base,
    input  logic              cfg_hpd,
    input  logic              cfg_off,
    input  logic              xl_start,
    input  logic [VA_W-1:0]   xl_va,
    input  logic              xl_write,
    output logic              xl_busy,
    output logic              xl_done,
    output logic [1:0]        xl_fault,
    output logic [PA_W-1:0]   xl_fault_addr,
    output logic [PA_W-1:0]   xl_pa,
    output logic [VA_W-1:0]   xl_va_out,
    output logic [VA_W-1:0]   xl_mask,
    output logic [1:0]        xl_perm,
    output logic [1:0]        xl_level,
    output logic [GLOG_W-1:0] xl_gran,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DESC_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_err
);
    localparam int LVL_W = PTW_LVL_W;
    localparam int SH_W  = PTW_SH_W;
    localparam logic [VA_W-1:0] ONE_VA  = VA_W'(1);
    localparam logic [PA_W-1:0] ONES_PA = {PA_W{1'b1}};

    typedef struct packed {
        ptw_state_e        st;
        logic [VA_W-1:0]   va;
        logic              wr;
        logic [1:0]        gran;
        logic [TSZ_W-1:0]  tsz;
        logic [PA_W-1:0]   ttb;
        logic              hpd;
        logic              off;
        logic [LVL_W-1:0]  lvl;
        logic [PA_W-1:0]   base;
        logic [PA_W-1:0]   daddr;
        logic              done;
        ptw_fault_e        fault;
        logic [PA_W-1:0]   faddr;
        logic [PA_W-1:0]   pa;
        logic [VA_W-1:0]   va_out;
        logic [VA_W-1:0]   mask;
        logic [1:0]        perm;
        logic [LVL_W-1:0]  level;
        logic [GLOG_W-1:0] glog;
    } walk_s;

    walk_s r_d, r_q;

    logic [GLOG_W-1:0] gran_log;
    logic [LVL_W-1:0]  start_lvl;
    logic              geom_ok;
    logic [SH_W-1:0]   base_mbits;
    logic [SH_W-1:0]   shift;
    logic [SH_W-1:0]   idx_bits;
    ptw_kind_e         kind;
    logic [PA_W-1:0]   next_base;
    logic [PA_W-1:0]   leaf_pa;
    logic              leaf_ro;
    logic              tbl_ro;
    logic [VA_W-1:0]   idx_full;
    logic [PA_W-1:0]   req_addr;
    logic [VA_W-1:0]   leaf_mask;
    logic              unused_top;

    assign unused_top = ^cfg_base[VA_W-1:PA_W];

    ptw_geom #(
        .TSZ_W (TSZ_W),
        .GLOG_W(GLOG_W),
        .LVL_W (LVL_W),
        .SH_W  (SH_W)
    ) u_geom (
        .gran_sel  (r_q.gran),
        .tsz       (r_q.tsz),
        .lvl       (r_q.lvl),
        .gran_log  (gran_log),
        .start_lvl (start_lvl),
        .geom_ok   (geom_ok),
        .base_mbits(base_mbits),
        .shift     (shift),
        .idx_bits  (idx_bits)
    );

    ptw_desc #(
        .DESC_W(DESC_W),
        .PA_W  (PA_W),
        .GLOG_W(GLOG_W),
        .LVL_W (LVL_W),
        .SH_W  (SH_W)
    ) u_desc (
        .desc     (mem_rsp_data),
        .lvl      (r_q.lvl),
        .gran_log (gran_log),
        .shift    (shift),
        .kind     (kind),
        .next_base(next_base),
        .leaf_pa  (leaf_pa),
        .leaf_ro  (leaf_ro),
        .tbl_ro   (tbl_ro)
    );

    // descriptor address for the current level
    assign idx_full  = (r_q.va >> shift) & ((ONE_VA << idx_bits) - ONE_VA);
    assign req_addr  = r_q.base + {idx_full[PA_W-4:0], 3'b000};
    assign leaf_mask = (ONE_VA << shift) - ONE_VA;

    function automatic walk_s end_fault(walk_s s, ptw_fault_e f, logic [PA_W-1:0] a);
        walk_s t;
        t        = s;
        t.st     = ST_IDLE;
        t.done   = 1'b1;
        t.fault  = f;
        t.faddr  = a;
        t.pa     = '0;
        t.va_out = '0;
        t.mask   = '0;
        t.perm   = 2'b00;
        t.level  = s.lvl;
        t.glog   = gran_log;
        return t;
    endfunction

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (xl_start) begin
                    r_d.st   = ST_SETUP;
                    r_d.va   = xl_va;
                    r_d.wr   = xl_write;
                    r_d.gran = cfg_gran;
                    r_d.tsz  = cfg_tsz;
                    r_d.ttb  = cfg_base[PA_W-1:0];
                    r_d.hpd  = cfg_hpd;
                    r_d.off  = cfg_off;
                    r_d.lvl  = '0;
                end
            end
            ST_SETUP: begin
                if (r_q.off || !geom_ok) begin
                    r_d = end_fault(r_q, FLT_XLAT, '0);
                end else begin
                    r_d.lvl  = start_lvl;
                    r_d.base = r_q.ttb & (ONES_PA << base_mbits);
                    r_d.st   = ST_REQ;
                end
            end
            ST_REQ: begin
                if (mem_req_ready) begin
                    r_d.daddr = req_addr;
                    r_d.st    = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        r_d = end_fault(r_q, FLT_ABORT, r_q.daddr);
                    end else begin
                        unique case (kind)
                            K_TABLE: begin
                                if (tbl_ro && r_q.wr && !r_q.hpd) begin
                                    r_d = end_fault(r_q, FLT_PERM, r_q.daddr);
                                end else begin
                                    r_d.base = next_base;
                                    r_d.lvl  = r_q.lvl + LVL_W'(1);
                                    r_d.st   = ST_REQ;
                                end
                            end
                            K_PAGE, K_BLOCK: begin
                                if (leaf_ro && r_q.wr) begin
                                    r_d = end_fault(r_q, FLT_PERM, r_q.daddr);
                                end else begin
                                    r_d.st     = ST_IDLE;
                                    r_d.done   = 1'b1;
                                    r_d.fault  = FLT_NONE;
                                    r_d.faddr  = '0;
                                    r_d.pa     = leaf_pa;
                                    r_d.mask   = leaf_mask;
                                    r_d.va_out = r_q.va & ~leaf_mask;
                                    r_d.perm   = leaf_ro ? 2'b01 : 2'b11;
                                    r_d.level  = r_q.lvl;
                                    r_d.glog   = gran_log;
                                end
                            end
                            default: begin
                                r_d = end_fault(r_q, FLT_XLAT, r_q.daddr);
                            end
                        endcase
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign xl_busy       = (r_q.st != ST_IDLE);
    assign xl_done       = r_q.done;
    assign xl_fault      = r_q.fault;
    assign xl_fault_addr = r_q.faddr;
    assign xl_pa         = r_q.pa;
    assign xl_va_out     = r_q.va_out;
    assign xl_mask       = r_q.mask;
    assign xl_perm       = r_q.perm;
    assign xl_level      = r_q.level;
    assign xl_gran       = r_q.glog;
    assign mem_req_valid = (r_q.st == ST_REQ);
    assign mem_req_addr  = req_addr;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
    import ptw_pkg::*;
#(
    parameter int VA_W = PTW_VA_W,
    parameter int PA_W = PTW_PA_W
) (
    input logic            clk,
    input logic            rst_n,
    input logic            xl_busy,
    input logic            xl_done,
    input logic [1:0]      xl_fault,
    input logic [1:0]      xl_perm,
    input logic [VA_W-1:0] xl_va_out,
    input logic [VA_W-1:0] xl_mask,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PA_W-1:0] mem_req_addr
);

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        xl_done |=> !xl_done);

    assert_done_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        xl_done |-> !xl_busy);

    assert_req_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> xl_busy);

    assert_req_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

    // covers R6 as well: every fault class leaves no rights
    assert_fault_noperm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_done && xl_fault != 2'd0) |-> (xl_perm == 2'b00));

    assert_leaf_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_done && xl_fault == 2'd0) |-> ((xl_va_out & xl_mask) == '0));

endmodule

bind ptw_walker ptw_walker_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .xl_busy      (xl_busy),
    .xl_done      (xl_done),
    .xl_fault     (xl_fault),
    .xl_perm      (xl_perm),
    .xl_va_out    (xl_va_out),
    .xl_mask      (xl_mask),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr)
);

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb;
    import ptw_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_gran = 2'd0;
    logic [5:0]  cfg_tsz = 6'd16;
    logic [63:0] cfg_base = '0;
    logic        cfg_hpd = 1'b0;
    logic        cfg_off = 1'b0;
    logic        xl_start = 1'b0;
    logic [63:0] xl_va = '0;
    logic        xl_write = 1'b0;
    logic        xl_busy, xl_done;
    logic [1:0]  xl_fault, xl_perm, xl_level;
    logic [47:0] xl_fault_addr, xl_pa, mem_req_addr;
    logic [63:0] xl_va_out, xl_mask;
    logic [4:0]  xl_gran;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int req_cnt = 0;

    logic [63:0] mem_a [logic [47:0]];
    logic        err_en = 1'b0;
    logic [47:0] err_addr = '0;
    logic        pend = 1'b0;
    logic [47:0] pend_addr = '0;

    always #2.5 clk = ~clk;

    ptw_walker u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_gran(cfg_gran), .cfg_tsz(cfg_tsz), .cfg_base(cfg_base),
        .cfg_hpd(cfg_hpd), .cfg_off(cfg_off),
        .xl_start(xl_start), .xl_va(xl_va), .xl_write(xl_write),
        .xl_busy(xl_busy), .xl_done(xl_done), .xl_fault(xl_fault),
        .xl_fault_addr(xl_fault_addr), .xl_pa(xl_pa), .xl_va_out(xl_va_out),
        .xl_mask(xl_mask), .xl_perm(xl_perm), .xl_level(xl_level), .xl_gran(xl_gran),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err)
    );

    function automatic logic [63:0] rd(input logic [47:0] a);
        return mem_a.exists(a) ? mem_a[a] : 64'h0;
    endfunction

    // memory model: accepts at one falling edge, answers at the next
    always @(negedge clk) begin
        if (pend) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= rd(pend_addr);
            mem_rsp_err   <= err_en && (pend_addr == err_addr);
            pend          <= 1'b0;
        end else begin
            mem_rsp_valid <= 1'b0;
            mem_rsp_err   <= 1'b0;
        end
        if (rst_n && mem_req_valid && mem_req_ready) begin
            pend      <= 1'b1;
            pend_addr <= mem_req_addr;
            req_cnt   <= req_cnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] g, input logic [5:0] t,
                           input logic [63:0] b, input logic h, input logic o);
        cfg_gran = g; cfg_tsz = t; cfg_base = b; cfg_hpd = h; cfg_off = o;
        mem_a.delete();
        err_en = 1'b0;
    endtask

    task automatic pulse_start(input logic [63:0] va, input logic wr);
        @(negedge clk);
        xl_start = 1'b1; xl_va = va; xl_write = wr;
        @(negedge clk);
        xl_start = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (xl_done !== 1'b1 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (xl_done !== 1'b1) chk({tag, " done"}, 64'(xl_done), 64'h1);
    endtask

    task automatic walk(input logic [63:0] va, input logic wr, input string tag);
        pulse_start(va, wr);
        wait_done(tag);
    endtask

    task automatic expect_leaf(input string tag, input logic [47:0] pa, input logic [63:0] va,
                               input logic [63:0] mask, input logic [1:0] perm,
                               input logic [1:0] lvl, input logic [4:0] g);
        chk({tag, " R5 fault"}, 64'(xl_fault), 64'h0);
        chk({tag, " R5 pa"}, 64'(xl_pa), 64'(pa));
        chk({tag, " R5 mask"}, xl_mask, mask);
        chk({tag, " R5 va_out"}, xl_va_out, va & ~mask);
        chk({tag, " R5 perm"}, 64'(xl_perm), 64'(perm));
        chk({tag, " R5 level"}, 64'(xl_level), 64'(lvl));
        chk({tag, " R12 gran"}, 64'(xl_gran), 64'(g));
    endtask

    task automatic expect_fault(input string tag, input logic [1:0] f, input logic [47:0] a);
        chk({tag, " code"}, 64'(xl_fault), 64'(f));
        chk({tag, " addr"}, 64'(xl_fault_addr), 64'(a));
        chk({tag, " R9 perm none"}, 64'(xl_perm), 64'h0);
    endtask

    // 4 KB granule, tsz 16: four levels from 0 through 3
    task automatic build_4k_chain(input logic [63:0] va, input logic [63:0] leaf);
        mem_a[48'h10000 + {va[47:39], 3'b000}] = 64'h0000_0000_0002_0FF3;
        mem_a[48'h20000 + {va[38:30], 3'b000}] = 64'h0000_0000_0003_0003;
        mem_a[48'h30000 + {va[29:21], 3'b000}] = 64'h0000_0000_0004_0003;
        mem_a[48'h40000 + {va[20:12], 3'b000}] = leaf;
    endtask

    task automatic t_reset;
        chk("R1 busy after reset", 64'(xl_busy), 64'h0);
        chk("R1 done after reset", 64'(xl_done), 64'h0);
        chk("R1 req after reset", 64'(mem_req_valid), 64'h0);
    endtask

    task automatic t_four_level;
        logic [63:0] va = 64'h0000_1234_5678_9ABC;
        int c0;
        set_cfg(2'd0, 6'd16, 64'hFFFF_0000_0001_0ABC, 1'b0, 1'b0);
        build_4k_chain(va, 64'h0000_0000_7654_3003);
        c0 = req_cnt;
        walk(va, 1'b1, "R2 four-level");
        expect_leaf("R4 four-level", 48'h7654_3000, va, 64'hFFF, 2'b11, 2'd3, 5'd12);
        chk("R3 one read per level", 64'(req_cnt - c0), 64'd4);
        @(negedge clk);
        chk("R11 done one cycle", 64'(xl_done), 64'h0);
        chk("R1 idle after walk", 64'(xl_busy), 64'h0);
    endtask

    task automatic t_block_l1;
        logic [63:0] va = 64'h0000_0045_6789_ABCD;
        int c0;
        set_cfg(2'd0, 6'd25, 64'hFF00_0000_0005_0ABC, 1'b0, 1'b0);
        mem_a[48'h50000 + {va[38:30], 3'b000}] = 64'h0000_0000_8123_4001;
        c0 = req_cnt;
        walk(va, 1'b0, "R2 block L1");
        expect_leaf("R5 block L1", 48'h8000_0000, va, 64'h3FFF_FFFF, 2'b11, 2'd1, 5'd12);
        chk("R2 start level 1 single read", 64'(req_cnt - c0), 64'd1);
    endtask

    task automatic t_leaf_ro;
        logic [63:0] va = 64'h0000_0012_3456_789A;
        logic [47:0] da;
        set_cfg(2'd0, 6'd25, 64'h5_0000, 1'b0, 1'b0);
        da = 48'h50000 + {va[38:30], 3'b000};
        mem_a[da] = 64'h0000_0000_8000_0081;
        walk(va, 1'b1, "R9 ro write");
        expect_fault("R9 ro write", 2'd2, da);
        walk(va, 1'b0, "R9 ro read");
        expect_leaf("R9 ro read", 48'h8000_0000, va, 64'h3FFF_FFFF, 2'b01, 2'd1, 5'd12);
    endtask

    task automatic t_table_ro;
        logic [63:0] va = 64'h0000_0012_3456_789A;
        logic [47:0] da;
        set_cfg(2'd0, 6'd25, 64'h5_0000, 1'b0, 1'b0);
        da = 48'h50000 + {va[38:30], 3'b000};
        mem_a[da] = 64'h4000_0000_0006_0003;
        mem_a[48'h60000 + {va[29:21], 3'b000}] = 64'h0000_0000_9000_0001;
        walk(va, 1'b1, "R10 table ro write");
        expect_fault("R10 table ro write", 2'd2, da);
        walk(va, 1'b0, "R10 table ro read");
        expect_leaf("R10 table ro read", 48'h9000_0000, va, 64'h1F_FFFF, 2'b11, 2'd2, 5'd12);
        cfg_hpd = 1'b1;
        walk(va, 1'b1, "R10 hpd write");
        expect_leaf("R10 hpd write", 48'h9000_0000, va, 64'h1F_FFFF, 2'b11, 2'd2, 5'd12);
    endtask

    task automatic t_invalid_reserved;
        logic [63:0] va = 64'h0000_0012_3456_789A;
        logic [63:0] vb = 64'h0000_1234_5678_9ABC;
        set_cfg(2'd0, 6'd25, 64'h5_0000, 1'b0, 1'b0);
        walk(va, 1'b0, "R6 invalid");
        expect_fault("R6 invalid", 2'd1, 48'h50000 + {va[38:30], 3'b000});
        set_cfg(2'd0, 6'd16, 64'h1_0000, 1'b0, 1'b0);
        build_4k_chain(vb, 64'h0000_0000_7654_3001);
        walk(vb, 1'b0, "R6 reserved");
        expect_fault("R6 reserved L3", 2'd1, 48'h40000 + {vb[20:12], 3'b000});
    endtask

    task automatic t_abort;
        logic [63:0] va = 64'h0000_1234_5678_9ABC;
        int c0;
        set_cfg(2'd0, 6'd16, 64'h1_0000, 1'b0, 1'b0);
        build_4k_chain(va, 64'h0000_0000_7654_3003);
        err_addr = 48'h30000 + {va[29:21], 3'b000};
        err_en = 1'b1;
        c0 = req_cnt;
        walk(va, 1'b0, "R7 abort");
        expect_fault("R7 abort", 2'd3, 48'h30000 + {va[29:21], 3'b000});
        chk("R7 reads up to abort", 64'(req_cnt - c0), 64'd3);
    endtask

    task automatic t_no_walk(input logic [1:0] g, input logic [5:0] t, input logic o,
                             input string tag);
        int c0;
        set_cfg(g, t, 64'h1_0000, 1'b0, o);
        mem_a[48'h10000] = 64'h0000_0000_0002_0003;
        c0 = req_cnt;
        walk(64'h0, 1'b0, tag);
        chk({tag, " R8 code"}, 64'(xl_fault), 64'h1);
        chk({tag, " R8 no reads"}, 64'(req_cnt - c0), 64'h0);
    endtask

    task automatic t_64k;
        logic [63:0] va = 64'h0000_0123_4567_89AB;
        set_cfg(2'd2, 6'd22, 64'h7_1234, 1'b0, 1'b0);
        mem_a[48'h70000 + {va[41:29], 3'b000}] = 64'h0000_0000_6000_0001;
        walk(va, 1'b0, "R12 64K");
        expect_leaf("R12 64K", 48'h6000_0000, va, 64'h1FFF_FFFF, 2'b11, 2'd2, 5'd16);
    endtask

    task automatic t_16k;
        logic [63:0] va = 64'h0000_000A_BCDE_F123;
        set_cfg(2'd1, 6'd28, 64'h9_5555, 1'b0, 1'b0);
        mem_a[48'h94000 + {va[35:25], 3'b000}] = 64'h0000_0000_000C_4003;
        mem_a[48'hC4000 + {va[24:14], 3'b000}] = 64'h0000_0000_1234_C003;
        walk(va, 1'b0, "R12 16K");
        expect_leaf("R12 16K", 48'h1234_C000, va, 64'h3FFF, 2'b11, 2'd3, 5'd14);
    endtask

    task automatic t_stall_restart;
        logic [63:0] va = 64'h0000_0045_6789_ABCD;
        set_cfg(2'd0, 6'd25, 64'h5_0000, 1'b0, 1'b0);
        mem_a[48'h50000 + {va[38:30], 3'b000}] = 64'h0000_0000_8123_4001;
        mem_a[48'h50000] = 64'h0000_0000_4000_0001;
        mem_req_ready = 1'b0;
        pulse_start(va, 1'b0);
        repeat (3) @(negedge clk);
        chk("R11 busy while stalled", 64'(xl_busy), 64'h1);
        chk("R11 request held", 64'(mem_req_addr), 64'(48'h50000 + {va[38:30], 3'b000}));
        pulse_start(64'h0, 1'b1);
        mem_req_ready = 1'b1;
        wait_done("R11 stall");
        expect_leaf("R11 restart ignored", 48'h8000_0000, va, 64'h3FFF_FFFF, 2'b11, 2'd1, 5'd12);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_four_level();
        t_block_l1();
        t_leaf_ro();
        t_table_ro();
        t_invalid_reserved();
        t_abort();
        t_no_walk(2'd0, 6'd16, 1'b1, "R8 disabled");
        t_no_walk(2'd3, 6'd16, 1'b0, "R8 bad granule");
        t_no_walk(2'd0, 6'd60, 1'b0, "R8 too small");
        t_no_walk(2'd0, 6'd0, 1'b0, "R8 too large");
        t_64k();
        t_16k();
        t_stall_restart();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule